// File: doc/BRIEF.md
# Dithered 6+2 PWM Generator

This block drives one PWM pin from an 8-bit duty value. It does not compare the duty against one 256-clock ramp. It splits every 256-clock PWM period into four 64-clock sub-cycles, so the pin toggles four times as often and an external filter sees a ripple frequency four times higher.

The six high bits of the duty value give every sub-cycle the same base high time. The two low bits spread the remaining resolution: the first sub-cycles of the period each get one extra high clock, and their number equals the two-bit value. The high time summed over one period therefore equals the 8-bit duty exactly.

The duty input is captured only when a new period begins, so a write partway through a period never breaks the waveform. An enable input stops the generator: the pin is driven low and the period restarts from its beginning.

Top module: `dither_pwm`

## Requirements
- R1: With enable held high, the output pattern repeats every 256 clocks and is built from four consecutive 64-clock sub-cycles, numbered 0 to 3 in time order.
- R2: The duty value is split into a base field (duty bits 7 down to 2, values 0 to 63) and a dither field (duty bits 1 down to 0, values 0 to 3). In sub-cycle i the output is high for the first base+1 clocks when i is below the dither field, and for the first base clocks otherwise. Over one period the high clocks add up to the 8-bit duty value.
- R3: The extended sub-cycles come first in the period. For example, a dither field of 1 extends only sub-cycle 0.
- R4: When the base field is 63 and a sub-cycle is extended, that sub-cycle is high for all 64 of its clocks.
- R5: A duty value of 0 keeps the output low for the whole period.
- R6: The duty input is sampled only at the clock edge that starts a period. A change partway through a period has no effect until the next period begins.
- R7: If enable is low at a clock edge, the output is low after that edge and the position returns to the start of a period. The first edge with enable high starts a period at sub-cycle 0, position 0, using the duty present at that edge.
- R8: Synchronous reset drives the output low, clears the position and clears the captured duty. After reset is released with enable high, the next period starts at position 0.
- R9: The output is registered. The level after the edge that processes position k is the level for position k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable. Low holds the generator idle with the output low |
| dutyIn | input | 8 | Duty value, captured at the start of each period |
| pwmOut | output | 1 | PWM output, registered |

## Verification
Two things can fall on the same edge: capturing a new duty value at the period boundary, and the compare for position 0 of sub-cycle 0, which has to use that new value and not the old one. The bench changes the duty input just before the wrap edge, and also at position 100, and then checks the next whole period bit by bit against the pattern of the new value. It also checks that the period still running when the mid-period write arrives keeps the old value. The same collision happens when enable returns and when reset is released, and the first sample after each is judged against position 0 of the current duty.

// File: rtl/dither_pwm_pkg.sv
package dither_pwm_pkg;
  parameter int DUTY_W = 8;
  parameter int SUB_W  = 2;
  localparam int POS_W = DUTY_W - SUB_W;
  localparam int CNT_W = DUTY_W;
  localparam int NSUB  = 1 << SUB_W;

  typedef struct packed {
    logic             loadNow;
    logic             runEn;
    logic [SUB_W-1:0] subIdx;
    logic [POS_W-1:0] pos;
  } ctrlStrobes_t;
endpackage

// File: rtl/dither_pwm_ctrl.sv
module dither_pwm_ctrl
  import dither_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output ctrlStrobes_t     strb,
  output logic [CNT_W-1:0] cntQ
);
  // Free-running period counter; high bits select the sub-cycle
  always_ff @(posedge clk) begin
    if (rst)      cntQ <= '0;
    else if (!en) cntQ <= '0;
    else          cntQ <= cntQ + CNT_W'(1);
  end

  always_comb begin
    strb.loadNow = en && (cntQ == '0);
    strb.runEn   = en;
    strb.subIdx  = cntQ[CNT_W-1 -: SUB_W];
    strb.pos     = cntQ[POS_W-1:0];
  end
endmodule

// File: rtl/dither_pwm_dp.sv
module dither_pwm_dp
  import dither_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [DUTY_W-1:0] dutyIn,
  output logic              pwmOut,
  output logic [DUTY_W-1:0] dutyQ
);
  logic [DUTY_W-1:0] dutyEff;
  logic [POS_W-1:0]  baseVal;
  logic [SUB_W-1:0]  ditherVal;
  logic [NSUB-1:0]   extVec;
  logic              extNow;
  logic [POS_W:0]    highTime;
  logic              inHigh;

  // A fresh value is used in the same cycle it is captured
  assign dutyEff   = strb.loadNow ? dutyIn : dutyQ;
  assign baseVal   = dutyEff[DUTY_W-1:SUB_W];
  assign ditherVal = dutyEff[SUB_W-1:0];

  // One flag per sub-cycle: extended when its index is below the dither field
  for (genvar g = 0; g < NSUB; g++) begin : gExt
    assign extVec[g] = SUB_W'(g) < ditherVal;
  end

  assign extNow   = extVec[strb.subIdx];
  assign highTime = {1'b0, baseVal} + (POS_W+1)'(extNow);
  assign inHigh   = {1'b0, strb.pos} < highTime;

  always_ff @(posedge clk) begin
    if (rst) begin
      dutyQ  <= '0;
      pwmOut <= 1'b0;
    end else begin
      if (strb.loadNow) dutyQ <= dutyIn;
      pwmOut <= strb.runEn && inHigh;
    end
  end
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
  import dither_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [7:0] dutyIn,
  output logic       pwmOut
);
  ctrlStrobes_t      strb;
  logic [CNT_W-1:0]  cntQ;
  logic [DUTY_W-1:0] dutyQ;

  dither_pwm_ctrl uCtrl (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .strb (strb),
    .cntQ (cntQ)
  );

  dither_pwm_dp uDp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .dutyIn (dutyIn),
    .pwmOut (pwmOut),
    .dutyQ  (dutyQ)
  );
endmodule

// File: rtl/dither_pwm_chk.sv
module dither_pwm_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [7:0] dutyIn,
  input logic       pwmOut,
  input logic [7:0] cntQ,
  input logic [7:0] dutyQ
);
  logic pastRst = 1'b0;
  always @(posedge clk) pastRst <= rst;

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> cntQ == ($past(cntQ) + 8'd1));

  // R6
  hold_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (cntQ != 8'd0) |=> $stable(dutyQ));

  // R6
  capture_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cntQ == 8'd0) |=> dutyQ == $past(dutyIn));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwmOut && cntQ == 8'd0));

  // R5
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cntQ == 8'd0 && dutyIn == 8'd0) |=> !pwmOut);

  // R8
  always @(posedge clk) begin
    if (pastRst) begin
      reset_clear_chk: assert (!pwmOut && cntQ == 8'd0 && dutyQ == 8'd0);
    end
  end
endmodule

bind dither_pwm dither_pwm_chk uChk (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .dutyIn (dutyIn),
  .pwmOut (pwmOut),
  .cntQ   (cntQ),
  .dutyQ  (dutyQ)
);

// File: tb/dither_pwm_test.sv
module dither_pwm_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] dutyIn = 8'h00;
  logic       pwmOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  dither_pwm uut (.clk(clk), .rst(rst), .en(en), .dutyIn(dutyIn), .pwmOut(pwmOut));

  always #5 clk = ~clk;

  // {duty, expected high clocks in sub-cycle 0}
  localparam logic [15:0] VEC [12] = '{
    {8'h00, 8'd0},  {8'h01, 8'd1},  {8'h02, 8'd1},  {8'h03, 8'd1},
    {8'h04, 8'd1},  {8'h07, 8'd2},  {8'h80, 8'd32}, {8'hA5, 8'd42},
    {8'hFC, 8'd63}, {8'hFD, 8'd64}, {8'hFF, 8'd64}, {8'h3E, 8'd16}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expBit(input logic [7:0] d, input int k);
    int base = int'(d[7:2]);
    int dith = int'(d[1:0]);
    int sub  = (k >> 6) & 3;
    int pos  = k & 63;
    return pos < (base + ((sub < dith) ? 1 : 0));
  endfunction

  // Samples one whole period; the next edge must process position 0.
  // A write of newD after sample chgAt tests that a running period is left alone.
  task automatic runPeriod(input logic [7:0] d, input int chgAt, input logic [7:0] newD,
                           output int mism, output int highs, output int sub0);
    mism = 0; highs = 0; sub0 = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (pwmOut !== expBit(d, k)) mism++;
      if (pwmOut === 1'b1) begin
        highs++;
        if (k < 64) sub0++;
      end
      if (k == chgAt) dutyIn = newD;
    end
  endtask

  // Idle for one edge, then enable so the next edge starts a period
  task automatic restart(input logic [7:0] d);
    @(negedge clk);
    en = 1'b0;
    dutyIn = d;
    @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int mism, highs, sub0;
    // R8: output low while reset is held
    repeat (3) @(negedge clk);
    check(pwmOut === 1'b0, "R8 reset low", int'(pwmOut), 0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R9: table walk
    for (int v = 0; v < 12; v++) begin
      restart(VEC[v][15:8]);
      runPeriod(VEC[v][15:8], -1, 8'h00, mism, highs, sub0);
      check(mism == 0, "R2 R9 pattern", mism, 0);
      check(highs == int'(VEC[v][15:8]), "R2 R5 period total", highs, int'(VEC[v][15:8]));
      check(sub0 == int'(VEC[v][7:0]), "R3 R4 sub-cycle 0", sub0, int'(VEC[v][7:0]));
    end

    // R1: second period repeats the first
    restart(8'h46);
    runPeriod(8'h46, -1, 8'h00, mism, highs, sub0);
    runPeriod(8'h46, -1, 8'h00, mism, highs, sub0);
    check(mism == 0, "R1 repeat", mism, 0);

    // R6: mid-period write ignored, then used from the next period
    restart(8'h21);
    runPeriod(8'h21, 100, 8'hC2, mism, highs, sub0);
    check(mism == 0, "R6 mid write ignored", mism, 0);
    runPeriod(8'hC2, 255, 8'h0B, mism, highs, sub0);
    check(mism == 0, "R6 new value next period", mism, 0);
    runPeriod(8'h0B, -1, 8'h00, mism, highs, sub0);
    check(mism == 0, "R6 write at wrap", mism, 0);

    // R7: disable partway through, then restart at position 0
    restart(8'hFF);
    repeat (10) @(negedge clk);
    check(pwmOut === 1'b1, "R7 running high", int'(pwmOut), 1);
    en = 1'b0;
    @(negedge clk);
    check(pwmOut === 1'b0, "R7 disabled low", int'(pwmOut), 0);
    dutyIn = 8'h06;
    repeat (5) @(negedge clk);
    en = 1'b1;
    runPeriod(8'h06, -1, 8'h00, mism, highs, sub0);
    check(mism == 0, "R7 restart at position 0", mism, 0);

    // R8: reset partway through, release with enable high
    dutyIn = 8'hFD;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(pwmOut === 1'b0, "R8 reset mid period", int'(pwmOut), 0);
    dutyIn = 8'h05;
    rst = 1'b0;
    runPeriod(8'h05, -1, 8'h00, mism, highs, sub0);
    check(mism == 0, "R8 restart after reset", mism, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule